// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

The controller gathers interrupt request lines arranged in groups and hands the processor a single request. Each clock, every line is captured into a request register that belongs to its group. A group counts as pending while any of its captured lines is high. Software gives each group a 2-bit priority level and a vector offset.

For each level, a cause register names the lowest-numbered pending group at that level. The processor supplies one mask bit per level and a global mask. The block delivers the highest pending level that is not masked, together with the offset of that level's cause group. A non-maskable request ignores all masks and overrides every level. It is delivered with its own level code and a fixed vector.

A small register bus gives read and write access to the group priority registers. It gives read-only access to the request and cause registers. The address is `{region[1:0], index[GW-1:0]}`, where GW = clog2(groups). Region 0 holds the priority registers, region 1 the request registers, region 2 the cause registers (indexed by level in index bits 1:0), and region 3 reads as zero. Line j of group g sits at bit `g*NLINE+j` of `irq_lines`.

Top module: `gpic_top`

## Requirements
- R1: After reset, `irq_valid` is 0, `irq_level` and `irq_vector` are 0, every priority register reads 0 (level 0, offset 0), and every cause register reads 0.
- R2: Every line is captured on each clock edge. A read of region 1, index g, returns group g's captured lines in bits NLINE-1:0, with zeros above.
- R3: A group is pending exactly while at least one of its captured lines is 1. It stops being pending once all of its lines have been captured low.
- R4: A write to region 0, index g, stores the level from wdata[31:30] and the offset from wdata[VEC_W-1:0]. A read returns the same fields in the same positions, with all other bits 0.
- R5: The cause register for level L (region 2, index L) reads bit 31 = 1 and bits GW-1:0 = the lowest-numbered pending group whose level is L. It reads 0 when no group is pending at L. Masks do not affect cause registers.
- R6: With no NMI, `irq_valid` is 1 when some level L has a pending group, with mask bit L clear and the global mask clear. `irq_level` is then the highest such L, and `irq_vector` is the offset of that level's cause group.
- R7: Setting `cpu_lvl_mask[L]` removes level L from delivery. Setting `cpu_glob_mask` removes all maskable levels. If nothing remains, `irq_valid` is 0.
- R8: A captured `nmi_req` gives `irq_valid`=1, `irq_level`=4 and `irq_vector`=NMI_VEC, regardless of any mask or pending group.
- R9: Bus writes to regions 1, 2 and 3 change no register.
- R10: Delivery outputs are registered. A line or NMI change shows on the outputs two edges later (capture, then output register). A mask change or priority write shows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NGRP*NLINE | Request lines, group-major |
| nmi_req | input | 1 | Non-maskable request |
| cpu_lvl_mask | input | 4 | Processor mask bit per level |
| cpu_glob_mask | input | 1 | Processor global mask |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | GW+2 | Register address {region, index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_valid | output | 1 | Request to the processor |
| irq_level | output | 3 | Delivered level, 0-3 maskable, 4 NMI |
| irq_vector | output | VEC_W | Delivered vector offset |

## Verification
A line or NMI change reaches the request registers and the cause registers one edge after it is driven, and reaches `irq_valid`, `irq_level` and `irq_vector` two edges after. A mask change or priority write reaches the outputs after one edge. The bench drives every input on a falling edge and counts whole clock periods before sampling on a later falling edge. Bus reads are combinational, so they are sampled shortly after the address is set. Scenarios that check latency look at the output both one edge early, when it must still be unchanged, and on the due edge.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  localparam int NLVL     = 4;
  localparam int LVL_W    = 2;
  localparam int OUT_LVL_W = 3;
  localparam logic [OUT_LVL_W-1:0] NMI_CODE = 3'd4;

  typedef enum logic [1:0] {
    RGN_PRIO  = 2'd0,
    RGN_REQ   = 2'd1,
    RGN_CAUSE = 2'd2,
    RGN_NONE  = 2'd3
  } region_e;

  // Pack a priority register image for the bus.
  function automatic logic [31:0] prio_image(input logic [LVL_W-1:0] lvl,
                                             input logic [31:0] ofs_zext);
    return {lvl, 30'(ofs_zext)};
  endfunction

  // Pack a cause register image for the bus.
  function automatic logic [31:0] cause_image(input logic vld,
                                              input logic [29:0] grp_zext);
    return vld ? {1'b1, 1'b0, grp_zext} : 32'd0;
  endfunction
endpackage

// File: rtl/gpic_sampler.sv
module gpic_sampler #(
  parameter int NGRP  = 64,
  parameter int NLINE = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NGRP*NLINE-1:0]       lines,
  output logic [NGRP-1:0][NLINE-1:0]  irr,
  output logic [NGRP-1:0]             grp_req
);
  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irr[g] <= '0;
        else        irr[g] <= lines[g*NLINE +: NLINE];
      end
      assign grp_req[g] = |irr[g];
    end
  endgenerate
endmodule

// File: rtl/gpic_prio_regs.sv
module gpic_prio_regs
  import gpic_pkg::*;
#(
  parameter int NGRP  = 64,
  parameter int VEC_W = 14,
  localparam int GW   = $clog2(NGRP)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [GW-1:0]               wr_grp,
  input  logic [31:0]                 wr_data,
  output logic [NGRP-1:0][LVL_W-1:0]  lvl,
  output logic [NGRP-1:0][VEC_W-1:0]  ofs
);
  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_ipr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl[g] <= '0;
          ofs[g] <= '0;
        end else if (wr_en && wr_grp == GW'(g)) begin
          lvl[g] <= wr_data[31:30];
          ofs[g] <= wr_data[VEC_W-1:0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpic_level_resolve.sv
module gpic_level_resolve
  import gpic_pkg::*;
#(
  parameter int NGRP = 64,
  localparam int GW  = $clog2(NGRP)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NGRP-1:0]             grp_req,
  input  logic [NGRP-1:0][LVL_W-1:0]  lvl,
  output logic [NLVL-1:0]             cause_vld,
  output logic [NLVL-1:0][GW-1:0]     cause_grp
);
  generate
    for (genvar L = 0; L < NLVL; L++) begin : g_lvl
      // Scan downward so the last hit is the lowest-numbered group.
      always_comb begin
        cause_vld[L] = 1'b0;
        cause_grp[L] = '0;
        for (int g = NGRP - 1; g >= 0; g--) begin
          if (grp_req[g] && lvl[g] == LVL_W'(L)) begin
            cause_vld[L] = 1'b1;
            cause_grp[L] = GW'(g);
          end
        end
      end

      // R5
      cause_names_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_vld[L] |-> (grp_req[cause_grp[L]] && lvl[cause_grp[L]] == LVL_W'(L)));

      // R5
      cause_clear_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_req == '0) |-> !cause_vld[L]);
    end
  endgenerate
endmodule

// File: rtl/gpic_top.sv
module gpic_top
  import gpic_pkg::*;
#(
  parameter int NGRP    = 64,
  parameter int NLINE   = 32,
  parameter int VEC_W   = 14,
  parameter int NMI_VEC = 'h100,
  localparam int GW     = $clog2(NGRP),
  localparam int AW     = GW + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NGRP*NLINE-1:0]  irq_lines,
  input  logic                   nmi_req,
  input  logic [3:0]             cpu_lvl_mask,
  input  logic                   cpu_glob_mask,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   irq_valid,
  output logic [2:0]             irq_level,
  output logic [VEC_W-1:0]       irq_vector
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

  logic [NGRP-1:0][NLINE-1:0] irr;
  logic [NGRP-1:0]            grp_req;
  logic [NGRP-1:0][LVL_W-1:0] ipr_lvl;
  logic [NGRP-1:0][VEC_W-1:0] ipr_ofs;
  logic [NLVL-1:0]            cause_vld;
  logic [NLVL-1:0][GW-1:0]    cause_grp;
  logic                       nmi_q;

  region_e       rgn;
  logic [GW-1:0] idx;
  logic          idx_ok;
  logic          prio_wr;
  logic          ro_wr;

  assign rgn     = region_e'(bus_addr[AW-1:AW-2]);
  assign idx     = bus_addr[GW-1:0];
  assign idx_ok  = (32'(idx) < NGRP);
  assign prio_wr = bus_wr && rgn == RGN_PRIO && idx_ok;
  assign ro_wr   = bus_wr && rgn != RGN_PRIO;

  gpic_sampler #(.NGRP(NGRP), .NLINE(NLINE)) u_sampler (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .irr(irr), .grp_req(grp_req)
  );

  gpic_prio_regs #(.NGRP(NGRP), .VEC_W(VEC_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_en(prio_wr), .wr_grp(idx),
    .wr_data(bus_wdata), .lvl(ipr_lvl), .ofs(ipr_ofs)
  );

  gpic_level_resolve #(.NGRP(NGRP)) u_resolve (
    .clk(clk), .rst_n(rst_n), .grp_req(grp_req), .lvl(ipr_lvl),
    .cause_vld(cause_vld), .cause_grp(cause_grp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= nmi_req;
  end

  // Register read mux
  always_comb begin
    bus_rdata = '0;
    unique case (rgn)
      RGN_PRIO:  if (idx_ok) bus_rdata = prio_image(ipr_lvl[idx], 32'(ipr_ofs[idx]));
      RGN_REQ:   if (idx_ok) bus_rdata = 32'(irr[idx]);
      RGN_CAUSE: bus_rdata = cause_image(cause_vld[idx[1:0]], 30'(cause_grp[idx[1:0]]));
      default:   bus_rdata = '0;
    endcase
  end

  // Delivery choice: named intermediate signals for the checks.
  logic [NLVL-1:0]      lvl_open;
  logic                 mask_any_open;
  logic [LVL_W-1:0]     win_lvl;
  logic                 nxt_valid;
  logic [2:0]           nxt_level;
  logic [VEC_W-1:0]     nxt_vector;

  assign lvl_open      = cause_vld & ~cpu_lvl_mask & {NLVL{~cpu_glob_mask}};
  assign mask_any_open = |lvl_open;

  always_comb begin
    win_lvl = '0;
    for (int L = 0; L < NLVL; L++) if (lvl_open[L]) win_lvl = LVL_W'(L);
  end

  always_comb begin
    nxt_valid  = 1'b0;
    nxt_level  = '0;
    nxt_vector = '0;
    if (nmi_q) begin
      nxt_valid  = 1'b1;
      nxt_level  = NMI_CODE;
      nxt_vector = NMI_V;
    end else if (mask_any_open) begin
      nxt_valid  = 1'b1;
      nxt_level  = {1'b0, win_lvl};
      nxt_vector = ipr_ofs[cause_grp[win_lvl]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= nxt_valid;
      irq_level  <= nxt_level;
      irq_vector <= nxt_vector;
    end
  end

  // R8
  nmi_overrides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |=> (irq_valid && irq_level == NMI_CODE && irq_vector == NMI_V));

  // R7
  glob_mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_q && cpu_glob_mask) |=> !irq_valid);

  // R6
  top_level_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_q && !cpu_glob_mask && !cpu_lvl_mask[3] && cause_vld[3])
      |=> (irq_valid && irq_level == 3'd3));

  // R9
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr |=> ($stable(ipr_lvl) && $stable(ipr_ofs)));

  // R3
  idle_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_q && grp_req == '0) |=> !irq_valid);
endmodule

// File: tb/gpic_top_bench.sv
module gpic_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NGRP  = 8;
  localparam int NLINE = 4;
  localparam int VEC_W = 8;
  localparam int NMIV  = 'hA5;
  localparam int AW    = 5;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NGRP*NLINE-1:0] lines = '0;
  logic                  nmi = 1'b0;
  logic [3:0]            lmask = '0;
  logic                  gmask = 1'b0;
  logic                  wr = 1'b0;
  logic [AW-1:0]         addr = '0;
  logic [31:0]           wdata = '0;
  logic [31:0]           rdata;
  logic                  ivalid;
  logic [2:0]            ilevel;
  logic [VEC_W-1:0]      ivec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpic_top #(.NGRP(NGRP), .NLINE(NLINE), .VEC_W(VEC_W), .NMI_VEC(NMIV)) u_gpic_top (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .nmi_req(nmi),
    .cpu_lvl_mask(lmask), .cpu_glob_mask(gmask), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_valid(ivalid),
    .irq_level(ilevel), .irq_vector(ivec)
  );

  function automatic logic [AW-1:0] ad(input int rgn, input int idx);
    return {2'(rgn), 3'(idx)};
  endfunction

  function automatic logic [31:0] prio_word(input int lvl, input int ofs);
    return (32'(lvl) << 30) | 32'(ofs & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_grp(input int g, input logic [NLINE-1:0] v);
    lines[g*NLINE +: NLINE] = v;
  endtask

  task automatic chk_out(input string req, input logic v, input int lvl, input int vec);
    chk(req, {31'd0, ivalid}, {31'd0, v});
    chk(req, 32'(ilevel), 32'(lvl));
    chk(req, 32'(ivec), 32'(vec));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk_out("R1", 1'b0, 0, 0);
    bus_read(ad(0, 3), d); chk("R1", d, 32'd0);
    bus_read(ad(0, 7), d); chk("R1", d, 32'd0);
    bus_read(ad(2, 0), d); chk("R1", d, 32'd0);
  endtask

  task automatic t_prio_rw;
    logic [31:0] d;
    bus_write(ad(0, 2), 32'h8F00_AB12);
    bus_read(ad(0, 2), d); chk("R4", d, prio_word(2, 'h12));
    bus_write(ad(0, 6), prio_word(2, 'h66));
    bus_read(ad(0, 6), d); chk("R4", d, prio_word(2, 'h66));
  endtask

  task automatic t_sample;
    logic [31:0] d;
    @(negedge clk);
    set_grp(5, 4'b0100);
    step(1);
    bus_read(ad(1, 5), d); chk("R2", d, 32'h4);
    chk_out("R10", 1'b0, 0, 0);
    step(1);
    chk_out("R10", 1'b1, 0, 0);
    set_grp(5, 4'b1010);
    step(1);
    bus_read(ad(1, 5), d); chk("R2", d, 32'hA);
    bus_read(ad(2, 0), d); chk("R3", d, 32'h8000_0005);
    set_grp(5, 4'b0000);
    step(1);
    bus_read(ad(2, 0), d); chk("R3", d, 32'd0);
    step(1);
    chk_out("R3", 1'b0, 0, 0);
  endtask

  task automatic t_lowest;
    logic [31:0] d;
    set_grp(2, 4'b0001);
    set_grp(6, 4'b1000);
    step(2);
    bus_read(ad(2, 2), d); chk("R5", d, 32'h8000_0002);
    chk_out("R5", 1'b1, 2, 'h12);
    set_grp(2, 4'b0000);
    step(2);
    bus_read(ad(2, 2), d); chk("R5", d, 32'h8000_0006);
    chk_out("R5", 1'b1, 2, 'h66);
  endtask

  task automatic t_highest;
    logic [31:0] d;
    bus_write(ad(0, 1), prio_word(3, 'h31));
    set_grp(1, 4'b0001);
    step(2);
    bus_read(ad(2, 3), d); chk("R5", d, 32'h8000_0001);
    chk_out("R6", 1'b1, 3, 'h31);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    lmask = 4'b1000;
    step(1);
    chk_out("R7", 1'b1, 2, 'h66);
    lmask = 4'b1100;
    step(1);
    chk_out("R7", 1'b0, 0, 0);
    lmask = 4'b0000;
    gmask = 1'b1;
    step(1);
    chk_out("R7", 1'b0, 0, 0);
    bus_read(ad(2, 3), d); chk("R5", d, 32'h8000_0001);
  endtask

  task automatic t_nmi;
    lmask = 4'b1111;
    nmi = 1'b1;
    step(1);
    chk_out("R10", 1'b0, 0, 0);
    step(1);
    chk_out("R8", 1'b1, 4, NMIV);
    nmi = 1'b0;
    lmask = 4'b0000;
    gmask = 1'b0;
    step(2);
    chk_out("R8", 1'b1, 3, 'h31);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    bus_write(ad(1, 1), 32'hFFFF_FFFF);
    bus_write(ad(2, 3), 32'hFFFF_FFFF);
    bus_write(ad(3, 1), 32'hFFFF_FFFF);
    bus_read(ad(0, 1), d); chk("R9", d, prio_word(3, 'h31));
    bus_read(ad(1, 1), d); chk("R9", d, 32'h1);
    bus_read(ad(2, 3), d); chk("R9", d, 32'h8000_0001);
    step(1);
    chk_out("R9", 1'b1, 3, 'h31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_prio_rw();
    t_sample();
    t_lowest();
    t_highest();
    t_mask();
    t_nmi();
    t_readonly();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule